// File: doc/BRIEF.md
# UART Baud Tick Generator

This block derives the oversampling baud tick for a UART from a single 32-bit control word. It takes two reference enable strobes, one marking crystal cycles and one marking system-clock cycles. Both are sampled in one clock domain. Fixed prescalers divide these strobes by 2, 3 and 4. A chain of control-bit selectors then picks one prescaled stream as the reference, and a 23-bit programmable divider turns that reference into a one-cycle tick.

All dividers are clock-enable counters that emit single-cycle strobes, so the block creates no derived clocks. A status output reports which reference is active. The control word is written through a simple write strobe and can be read back at any time. When a write changes any field that matters, every counter restarts, so the first tick after the write comes a full period later.

Top module: `uart_bclk_gen`

## Requirements
- R1: Control bits 22:0 hold the divisor N; the tick rate equals the selected reference strobe rate divided by N+1.
- R2: Bit 23 is the divisor enable; while it is 0, tick_o stays low.
- R3: Bit 24 picks the reference: 0 selects the system enable divided by 4, 1 selects the crystal path.
- R4: On the crystal path with bit 27 at 0, bit 26 at 0 selects the crystal enable divided by 3, and bit 26 at 1 selects the undivided crystal enable.
- R5: On the crystal path, bit 27 at 1 selects the crystal enable divided by 2, whatever bit 26 holds.
- R6: With parameter HAS_XTAL_SEL at 0, the crystal path is fixed at crystal divided by 3 and bits 26 and 27 have no effect.
- R7: A divisor of 0 produces a tick for every reference strobe.
- R8: A write takes effect on the cycle after the write strobe, and ctrl_rdata_o returns the last value written.
- R9: A write that changes bits 27, 26 or 24:0 restarts all counters, so the first tick comes one full period (reference ratio times N+1 enable strobes) after the write edge.
- R10: src_sel_o reports the active reference as 0 for system/4, 1 for crystal/3, 2 for the undivided crystal and 3 for crystal/2.
- R11: After reset, tick_o is 0, ctrl_rdata_o is 0 and src_sel_o is 0.
- R12: Prescalers advance only on cycles where their input enable is high, so gaps in an enable stretch the tick period by the same factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word write data |
| ctrl_rdata_o | output | 32 | Control word readback |
| xtal_en_i | input | 1 | Crystal reference enable strobe |
| sys_en_i | input | 1 | System clock reference enable strobe |
| tick_o | output | 1 | One-cycle baud tick |
| src_sel_o | output | 2 | Active reference code |

## Verification
Each reference choice is run with several divisors, and the tick period is measured between steady-state ticks. Each prescaler ratio multiplies the period by a different factor, so a wrong selector leg or a wrong prescale ratio shows up as a distinct wrong period. Enable streams with gaps (one strobe every 2 or 3 cycles) separate counting on strobes from counting on clock cycles. First-tick latency after a field change or after the enable bit rises exposes a missing counter restart. A second instance built without the crystal selectors shows that bits 26 and 27 are ignored there.

// File: rtl/uart_bclk_pkg.sv
package uart_bclk_pkg;
  localparam int unsigned DIV_W    = 23;
  localparam int unsigned BIT_USE  = 23;
  localparam int unsigned BIT_XSRC = 24;
  localparam int unsigned BIT_XRAW = 26;
  localparam int unsigned BIT_XD2  = 27;

  typedef enum logic [1:0] {
    SRC_SYS_D4  = 2'd0,
    SRC_XTAL_D3 = 2'd1,
    SRC_XTAL    = 2'd2,
    SRC_XTAL_D2 = 2'd3
  } src_e;
endpackage

// File: rtl/uart_bclk_prescale.sv
module uart_bclk_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic stb_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign stb_o = en_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  // R12
  hold_without_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q));

  // R12
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/uart_bclk_srcsel.sv
module uart_bclk_srcsel
  import uart_bclk_pkg::*;
#(
  parameter bit HAS_XTAL_SEL = 1'b1
) (
  input  logic       sel_xsrc_i,
  input  logic       sel_xraw_i,
  input  logic       sel_xd2_i,
  input  logic       sys_d4_i,
  input  logic       xtal_i,
  input  logic       xtal_d3_i,
  input  logic       xtal_d2_i,
  output logic       ref_stb_o,
  output logic [1:0] src_o
);
  src_e src;

  always_comb begin
    if (!sel_xsrc_i)                    src = SRC_SYS_D4;
    else if (HAS_XTAL_SEL && sel_xd2_i) src = SRC_XTAL_D2;
    else if (HAS_XTAL_SEL && sel_xraw_i) src = SRC_XTAL;
    else                                src = SRC_XTAL_D3;
  end

  always_comb begin
    unique case (src)
      SRC_SYS_D4:  ref_stb_o = sys_d4_i;
      SRC_XTAL_D3: ref_stb_o = xtal_d3_i;
      SRC_XTAL:    ref_stb_o = xtal_i;
      default:     ref_stb_o = xtal_d2_i;
    endcase
  end

  assign src_o = src;
endmodule

// File: rtl/uart_bclk_divider.sv
module uart_bclk_divider
  import uart_bclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             use_i,
  input  logic [DIV_W-1:0] field_i,
  input  logic             ref_stb_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (clr_i || !use_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (ref_stb_i) begin
        if (cnt_q >= field_i) begin
          cnt_q  <= '0;
          tick_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign tick_o = tick_q;

  // R1
  tick_needs_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tick_q) |-> $past(ref_stb_i));

  // R2
  gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !use_i |=> !tick_q);

  // R7
  zero_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_i && !clr_i && ref_stb_i && field_i == '0) |=> tick_q);
endmodule

// File: rtl/uart_bclk_gen.sv
module uart_bclk_gen
  import uart_bclk_pkg::*;
#(
  parameter bit          HAS_XTAL_SEL = 1'b1,
  parameter int unsigned SYS_DIV      = 4,
  parameter int unsigned XTAL_DIV_A   = 3,
  parameter int unsigned XTAL_DIV_B   = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_we_i,
  input  logic [31:0] ctrl_wdata_i,
  output logic [31:0] ctrl_rdata_o,
  input  logic        xtal_en_i,
  input  logic        sys_en_i,
  output logic        tick_o,
  output logic [1:0]  src_sel_o
);
  localparam logic [31:0] LIVE_MASK =
    (32'd1 << BIT_XD2) | (32'd1 << BIT_XRAW) | (32'd1 << BIT_XSRC) |
    (32'd1 << BIT_USE) | ((32'd1 << DIV_W) - 32'd1);

  logic [31:0] ctrl_q;
  logic        reload;
  logic        sys_d4, xtal_d3, xtal_d2, xtal_raw, ref_stb;

  // any change in a live field restarts every counter
  assign reload = ctrl_we_i && (((ctrl_wdata_i ^ ctrl_q) & LIVE_MASK) != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
  end

  assign ctrl_rdata_o = ctrl_q;
  assign xtal_raw     = xtal_en_i && !reload;

  uart_bclk_prescale #(.DIV(SYS_DIV)) i_pre_sys (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(reload), .en_i(sys_en_i), .stb_o(sys_d4));

  uart_bclk_prescale #(.DIV(XTAL_DIV_A)) i_pre_xa (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(reload), .en_i(xtal_en_i), .stb_o(xtal_d3));

  generate
    if (HAS_XTAL_SEL) begin : g_xsel
      uart_bclk_prescale #(.DIV(XTAL_DIV_B)) i_pre_xb (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(reload), .en_i(xtal_en_i), .stb_o(xtal_d2));
    end else begin : g_no_xsel
      assign xtal_d2 = 1'b0;
    end
  endgenerate

  uart_bclk_srcsel #(.HAS_XTAL_SEL(HAS_XTAL_SEL)) i_srcsel (
    .sel_xsrc_i(ctrl_q[BIT_XSRC]),
    .sel_xraw_i(ctrl_q[BIT_XRAW]),
    .sel_xd2_i (ctrl_q[BIT_XD2]),
    .sys_d4_i  (sys_d4),
    .xtal_i    (xtal_raw),
    .xtal_d3_i (xtal_d3),
    .xtal_d2_i (xtal_d2),
    .ref_stb_o (ref_stb),
    .src_o     (src_sel_o)
  );

  uart_bclk_divider i_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (reload),
    .use_i    (ctrl_q[BIT_USE]),
    .field_i  (ctrl_q[DIV_W-1:0]),
    .ref_stb_i(ref_stb),
    .tick_o   (tick_o)
  );

  // R8
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> ctrl_rdata_o == $past(ctrl_wdata_i));

  // R3
  sys_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[BIT_XSRC]) |-> src_sel_o == 2'd0);
endmodule

// File: tb/test_uart_bclk_gen.sv
`timescale 1ns/1ps
module test_uart_bclk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_f;
  logic        xtal_en = 1'b1, sys_en = 1'b1;
  logic        tick, tick_f;
  logic [1:0]  src, src_f;
  int          xper = 1, sper = 1, ecnt = 0;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  uart_bclk_gen i_uart_bclk_gen (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(we), .ctrl_wdata_i(wdata),
    .ctrl_rdata_o(rdata), .xtal_en_i(xtal_en), .sys_en_i(sys_en),
    .tick_o(tick), .src_sel_o(src));

  uart_bclk_gen #(.HAS_XTAL_SEL(1'b0)) i_uart_bclk_gen_fixed (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(we), .ctrl_wdata_i(wdata),
    .ctrl_rdata_o(rdata_f), .xtal_en_i(xtal_en), .sys_en_i(sys_en),
    .tick_o(tick_f), .src_sel_o(src_f));

  always @(negedge clk) begin
    ecnt++;
    xtal_en = (ecnt % xper) == 0;
    sys_en  = (ecnt % sper) == 0;
  end

  localparam int NV = 7;
  localparam logic [31:0] V_CTRL [NV] = '{32'h0080_0002, 32'h0180_0001, 32'h0580_0004,
    32'h0980_0003, 32'h0180_0000, 32'h0080_0001, 32'h0D80_0002};
  localparam int V_XP  [NV] = '{1, 1, 1, 1, 2, 1, 1};
  localparam int V_SP  [NV] = '{1, 1, 1, 1, 1, 3, 1};
  localparam int V_PER [NV] = '{12, 6, 5, 8, 6, 24, 6};
  localparam int V_SRC [NV] = '{0, 1, 2, 3, 1, 0, 3};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [31:0] v);
    @(negedge clk);
    we = 1'b1; wdata = v;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic measure(input bit fixed, output int p);
    int t = 0, n = 0, first = 0;
    p = -1;
    while (n < 3 && t < 2000) begin
      @(negedge clk);
      t++;
      if (fixed ? tick_f : tick) begin
        n++;
        if (n == 2) first = t;
        if (n == 3) p = t - first;
      end
    end
  endtask

  task automatic latency(output int l);
    l = -1;
    for (int k = 1; k <= 500; k++) begin
      @(negedge clk);
      if (tick) begin l = k; break; end
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8ns * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int p, l, cnt;
    repeat (3) @(negedge clk);
    // R11
    check("R11 tick", tick, 0);
    check("R11 rdata", rdata, 0);
    check("R11 src", src, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R11 tick idle", tick, 0);

    // R1 R3 R4 R5 R7 R10 R12: vector table
    for (int i = 0; i < NV; i++) begin
      xper = V_XP[i]; sper = V_SP[i];
      write_ctrl(V_CTRL[i]);
      check("R10 src", src, V_SRC[i]);
      measure(1'b0, p);
      check($sformatf("R1 period vec%0d", i), p, V_PER[i]);
    end
    xper = 1; sper = 1;

    // R8 readback and next-cycle effect
    write_ctrl(32'h0180_0005);
    check("R8 rdata", rdata, 32'h0180_0005);
    check("R8 src next cycle", src, 1);

    // R2: gate clear, divisor 0, no ticks
    write_ctrl(32'h0000_0000);
    cnt = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
    check("R2 no tick", cnt, 0);

    // R9: gate rising restarts, full period 4*3
    write_ctrl(32'h0080_0002);
    latency(l);
    check("R9 first tick after enable", l, 12);
    repeat (5) @(negedge clk);
    write_ctrl(32'h0080_0001);
    latency(l);
    check("R9 first tick after field change", l, 8);
    write_ctrl(32'h0180_0003);
    latency(l);
    check("R9 first tick crystal/3", l, 12);

    // R6: fixed variant ignores bits 26/27
    write_ctrl(32'h0580_0001);
    check("R6 src fixed", src_f, 1);
    check("R4 src main", src, 2);
    measure(1'b1, p);
    check("R6 period fixed", p, 6);
    measure(1'b0, p);
    check("R4 period main", p, 2);
    write_ctrl(32'h0980_0001);
    measure(1'b1, p);
    check("R6 bit27 ignored", p, 6);

    finish_run();
  end
endmodule